// File: doc/BRIEF.md
# Flash Page Write Latch

This block gathers one program page of 32 bytes ahead of a flash array write. Software, running from memory outside the flash, issues byte writes on a simple strobe bus. The first write of a page must fall on a 32-byte boundary. Every later write must target the next address in turn. The block keeps the page base address and every data byte. After the 32nd byte it raises a ready flag, which holds until the programming sequencer acknowledges the page.

The page base also selects one of two address banks, so the sequencer knows which half of the array to drive. A misaligned first byte, a break in the address run, or a write that arrives while a finished page is still waiting each raise a one-cycle error pulse. A separate gate refuses array read requests while a program or erase operation is active. The sequencer reads the stored bytes back by index.

Top module: `flash_page_latch`

## Requirements
- R1: When no page is open and none is ready, a write whose address has its low 5 bits zero (low byte 0x00, 0x20, 0x40, 0x60, 0x80, 0xA0, 0xC0 or 0xE0) opens a page. That write becomes byte 0, and the rest of the storage is set to 0xFF.
- R2: When no page is open, a write with a nonzero low 5-bit address field is discarded. `err_align` is high for exactly the one cycle after the clock edge that sampled it, and storage does not change.
- R3: While a page is open, a write at page base plus the current byte count is stored at that index. The edge that stores byte 31 makes `page_ready` high from the following cycle.
- R4: While a page is open, a write at any other address is discarded and `err_seq` pulses for one cycle. The partial page is dropped: every stored byte reads 0xFF, and the next write must again be an aligned start.
- R5: `page_ready` stays high until a clock edge samples `page_ack` high. From the cycle after that edge it is low.
- R6: A write sampled while `page_ready` is high is ignored, and `err_overrun` pulses for one cycle. This still applies when `page_ack` is high at the same edge.
- R7: `page_base` holds address bits 17:5 of the page's first write. `bank_hi` is 0 for pages in 0x00000–0x1FFFF and 1 for pages in 0x20000–0x3FFFF.
- R8: `page_byte` shows, without delay, the stored byte at index `rd_idx`. For a complete page this is the data of the write at base plus that index, including 0xFF padding bytes.
- R9: `rd_grant` follows `rd_req` while `op_active` is low and is held low while `op_active` is high.
- R10: After reset, `page_ready` and all error pulses are low and every stored byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 18 | Byte write address |
| wr_data | input | 8 | Byte write data |
| page_ack | input | 1 | Sequencer has taken the ready page |
| op_active | input | 1 | A program or erase operation is running |
| rd_req | input | 1 | Array read request |
| rd_grant | output | 1 | Array read permitted |
| page_ready | output | 1 | Complete page held and waiting |
| page_base | output | 13 | Page address, bits 17:5 |
| bank_hi | output | 1 | 0 = lower bank, 1 = upper bank |
| err_align | output | 1 | Misaligned page start (one-cycle pulse) |
| err_seq | output | 1 | Non-consecutive address (one-cycle pulse) |
| err_overrun | output | 1 | Write while page ready (one-cycle pulse) |
| rd_idx | input | 5 | Byte index for readback |
| page_byte | output | 8 | Stored byte at `rd_idx` |

## Verification
Two events can share one clock edge: the acknowledge that releases a finished page, and a new byte write. The bench drives `page_ack` and `wr_en` in the same cycle while a page is ready. It expects an overrun pulse from its scoreboard queue and `page_ready` low afterwards. It then reads byte 0 back to confirm that the colliding write did not open a new page.

// File: rtl/fpl_pkg.sv
package fpl_pkg;

    localparam int unsigned FPL_ADDR_W     = 18;
    localparam int unsigned FPL_DATA_W     = 8;
    localparam int unsigned FPL_PAGE_BYTES = 32;
    localparam int unsigned FPL_IDX_W      = $clog2(FPL_PAGE_BYTES);
    localparam int unsigned FPL_BASE_W     = FPL_ADDR_W - FPL_IDX_W;
    localparam logic [FPL_DATA_W-1:0] FPL_ERASED = '1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_FULL = 2'd2
    } fill_state_t;

    typedef struct packed {
        logic align;
        logic seq;
        logic overrun;
    } err_t;

    typedef struct packed {
        logic                  we;
        logic                  clr;
        logic [FPL_IDX_W-1:0]  idx;
    } store_cmd_t;

    function automatic logic is_page_start(input logic [FPL_ADDR_W-1:0] a);
        return a[FPL_IDX_W-1:0] == '0;
    endfunction

    function automatic logic bank_of(input logic [FPL_BASE_W-1:0] base);
        return base[FPL_BASE_W-1];
    endfunction

endpackage

// File: rtl/fpl_store.sv
module fpl_store #(
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              clr,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);

    logic [DEPTH-1:0][DATA_W-1:0] cells;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        logic [DATA_W-1:0] val;
        logic              hit;

        assign hit = we && (widx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                val <= '1;
            end else if (clr) begin
                val <= hit ? wdata : '1;
            end else if (hit) begin
                val <= wdata;
            end
        end

        assign cells[g] = val;
    end

    assign rdata = cells[ridx];

endmodule

// File: rtl/fpl_seq.sv
module fpl_seq
    import fpl_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [FPL_ADDR_W-1:0]  wr_addr,
    input  logic                   page_ack,
    output store_cmd_t             cmd,
    output logic [FPL_BASE_W-1:0]  base,
    output logic [FPL_IDX_W-1:0]   count,
    output logic                   filling,
    output logic                   ready,
    output err_t                   errs
);

    localparam logic [FPL_IDX_W-1:0] LAST_IDX = FPL_IDX_W'(FPL_PAGE_BYTES - 1);

    fill_state_t               state, state_n;
    logic [FPL_BASE_W-1:0]     base_n;
    logic [FPL_IDX_W-1:0]      count_n;
    err_t                      errs_n;
    logic                      in_order;

    assign in_order = (wr_addr == {base, count});

    always_comb begin
        state_n = state;
        base_n  = base;
        count_n = count;
        errs_n  = '0;
        cmd     = '0;
        unique case (state)
            ST_IDLE: begin
                if (wr_en) begin
                    if (is_page_start(wr_addr)) begin
                        base_n  = wr_addr[FPL_ADDR_W-1:FPL_IDX_W];
                        cmd.we  = 1'b1;
                        cmd.clr = 1'b1;
                        cmd.idx = '0;
                        count_n = FPL_IDX_W'(1);
                        state_n = ST_FILL;
                    end else begin
                        errs_n.align = 1'b1;
                    end
                end
            end
            ST_FILL: begin
                if (wr_en) begin
                    if (in_order) begin
                        cmd.we  = 1'b1;
                        cmd.idx = count;
                        if (count == LAST_IDX) begin
                            count_n = '0;
                            state_n = ST_FULL;
                        end else begin
                            count_n = count + 1'b1;
                        end
                    end else begin
                        errs_n.seq = 1'b1;
                        cmd.clr    = 1'b1;
                        count_n    = '0;
                        state_n    = ST_IDLE;
                    end
                end
            end
            ST_FULL: begin
                if (wr_en) begin
                    errs_n.overrun = 1'b1;
                end
                if (page_ack) begin
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            base  <= '0;
            count <= '0;
            errs  <= '0;
        end else begin
            state <= state_n;
            base  <= base_n;
            count <= count_n;
            errs  <= errs_n;
        end
    end

    assign filling = (state == ST_FILL);
    assign ready   = (state == ST_FULL);

endmodule

// File: rtl/fpl_rdgate.sv
module fpl_rdgate (
    input  logic rd_req,
    input  logic op_active,
    output logic rd_grant
);

    assign rd_grant = rd_req && !op_active;

endmodule

// File: rtl/flash_page_latch.sv
module flash_page_latch
    import fpl_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [FPL_ADDR_W-1:0]  wr_addr,
    input  logic [FPL_DATA_W-1:0]  wr_data,
    input  logic                   page_ack,
    input  logic                   op_active,
    input  logic                   rd_req,
    output logic                   rd_grant,
    output logic                   page_ready,
    output logic [FPL_BASE_W-1:0]  page_base,
    output logic                   bank_hi,
    output logic                   err_align,
    output logic                   err_seq,
    output logic                   err_overrun,
    input  logic [FPL_IDX_W-1:0]   rd_idx,
    output logic [FPL_DATA_W-1:0]  page_byte
);

    store_cmd_t              cmd;
    err_t                    errs;
    logic                    filling;
    logic [FPL_IDX_W-1:0]    fill_cnt;

    fpl_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .page_ack (page_ack),
        .cmd      (cmd),
        .base     (page_base),
        .count    (fill_cnt),
        .filling  (filling),
        .ready    (page_ready),
        .errs     (errs)
    );

    fpl_store #(
        .DEPTH  (FPL_PAGE_BYTES),
        .DATA_W (FPL_DATA_W)
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (cmd.we),
        .clr   (cmd.clr),
        .widx  (cmd.idx),
        .wdata (wr_data),
        .ridx  (rd_idx),
        .rdata (page_byte)
    );

    fpl_rdgate u_gate (
        .rd_req    (rd_req),
        .op_active (op_active),
        .rd_grant  (rd_grant)
    );

    assign bank_hi     = bank_of(page_base);
    assign err_align   = errs.align;
    assign err_seq     = errs.seq;
    assign err_overrun = errs.overrun;

endmodule

// File: rtl/fpl_checker.sv
module fpl_checker
    import fpl_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   wr_en,
    input logic [FPL_ADDR_W-1:0]  wr_addr,
    input logic                   page_ack,
    input logic                   op_active,
    input logic                   rd_grant,
    input logic                   page_ready,
    input logic [FPL_BASE_W-1:0]  page_base,
    input logic                   err_align,
    input logic                   err_seq,
    input logic                   err_overrun,
    input logic                   filling,
    input logic [FPL_IDX_W-1:0]   fill_cnt
);

    a_r2_misaligned_start: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !filling && !page_ready && (wr_addr[FPL_IDX_W-1:0] != '0))
        |=> (err_align && !filling));

    a_r4_break_drops_page: assert property (@(posedge clk) disable iff (rst)
        (wr_en && filling && (wr_addr != {page_base, fill_cnt}))
        |=> (err_seq && !filling && !page_ready));

    a_r5_ready_holds: assert property (@(posedge clk) disable iff (rst)
        (page_ready && !page_ack) |=> page_ready);

    a_r5_ack_releases: assert property (@(posedge clk) disable iff (rst)
        (page_ready && page_ack) |=> !page_ready);

    a_r6_overrun_flag: assert property (@(posedge clk) disable iff (rst)
        (page_ready && wr_en) |=> (err_overrun && !filling && $stable(page_base)));

    a_r9_read_blocked: assert property (@(posedge clk) disable iff (rst)
        op_active |-> !rd_grant);

    a_r10_single_error: assert property (@(posedge clk) disable iff (rst)
        $onehot0({err_align, err_seq, err_overrun}));

endmodule

bind flash_page_latch fpl_checker u_fpl_checker (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .page_ack    (page_ack),
    .op_active   (op_active),
    .rd_grant    (rd_grant),
    .page_ready  (page_ready),
    .page_base   (page_base),
    .err_align   (err_align),
    .err_seq     (err_seq),
    .err_overrun (err_overrun),
    .filling     (filling),
    .fill_cnt    (fill_cnt)
);

// File: tb/test_flash_page_latch.sv
`timescale 1ns/1ps
module test_flash_page_latch;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [17:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        page_ack = 1'b0;
    logic        op_active = 1'b0;
    logic        rd_req = 1'b0;
    logic        rd_grant;
    logic        page_ready;
    logic [12:0] page_base;
    logic        bank_hi;
    logic        err_align;
    logic        err_seq;
    logic        err_overrun;
    logic [4:0]  rd_idx = '0;
    logic [7:0]  page_byte;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;
        logic [12:0] base;
    } ev_t;
    localparam int EV_ALIGN = 0, EV_SEQ = 1, EV_OVR = 2, EV_READY = 3;

    ev_t        exp_q[$];
    logic [7:0] exp_bytes[32];
    logic       prev_ready = 1'b0;

    always #10 clk = ~clk;

    flash_page_latch i_flash_page_latch (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .page_ack(page_ack), .op_active(op_active), .rd_req(rd_req), .rd_grant(rd_grant),
        .page_ready(page_ready), .page_base(page_base), .bank_hi(bank_hi),
        .err_align(err_align), .err_seq(err_seq), .err_overrun(err_overrun),
        .rd_idx(rd_idx), .page_byte(page_byte)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic string ev_req(input int k);
        case (k)
            EV_ALIGN: return "R2";
            EV_SEQ:   return "R4";
            EV_OVR:   return "R6";
            default:  return "R3";
        endcase
    endfunction

    task automatic got_event(input int k);
        ev_t e;
        if (exp_q.size() == 0) begin
            check(1'b0, {ev_req(k), " unexpected event"}, k, 32'hFFFF);
        end else begin
            e = exp_q.pop_front();
            check(e.kind == k, {ev_req(e.kind), " event kind"}, k, e.kind);
            if (k == EV_READY && e.kind == EV_READY)
                check(page_base == e.base, "R7 page base at ready", page_base, e.base);
        end
    endtask

    // Monitor: compares produced events against the scoreboard queue
    always @(negedge clk) begin
        if (!rst) begin
            if (err_align)   got_event(EV_ALIGN);
            if (err_seq)     got_event(EV_SEQ);
            if (err_overrun) got_event(EV_OVR);
            if (page_ready && !prev_ready) got_event(EV_READY);
            prev_ready = page_ready;
        end else begin
            prev_ready = 1'b0;
        end
    end

    task automatic expect_ev(input int k, input logic [12:0] b);
        ev_t e;
        e.kind = k;
        e.base = b;
        exp_q.push_back(e);
    endtask

    task automatic wr(input logic [17:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk);
        page_ack = 1'b1;
        @(negedge clk);
        page_ack = 1'b0;
    endtask

    task automatic write_page(input logic [17:0] a, input logic [7:0] seed, input int used);
        expect_ev(EV_READY, a[17:5]);
        for (int i = 0; i < 32; i++) begin
            logic [7:0] d;
            d = (i < used) ? (seed ^ 8'(i * 7)) : 8'hFF;
            exp_bytes[i] = d;
            wr(a + 18'(i), d);
        end
    endtask

    task automatic check_bytes(input string req);
        for (int i = 0; i < 32; i++) begin
            rd_idx = 5'(i);
            #1;
            check(page_byte == exp_bytes[i], req, page_byte, exp_bytes[i]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state
        check(!page_ready, "R10 ready after reset", page_ready, 0);
        check(!err_align && !err_seq && !err_overrun, "R10 errors after reset",
              {err_align, err_seq, err_overrun}, 0);
        for (int i = 0; i < 32; i++) exp_bytes[i] = 8'hFF;
        check_bytes("R10 erased bytes after reset");

        // R9: read gating
        rd_req = 1'b1; op_active = 1'b0; #1;
        check(rd_grant == 1'b1, "R9 grant when idle", rd_grant, 1);
        op_active = 1'b1; #1;
        check(rd_grant == 1'b0, "R9 blocked during operation", rd_grant, 0);
        rd_req = 1'b0; #1;
        check(rd_grant == 1'b0, "R9 no request", rd_grant, 0);
        op_active = 1'b0;

        // R2: misaligned first writes are discarded
        expect_ev(EV_ALIGN, '0);
        wr(18'h00013, 8'h5A);
        expect_ev(EV_ALIGN, '0);
        wr(18'h00010, 8'h5B);
        check(!page_ready, "R2 no page after misaligned", page_ready, 0);
        check_bytes("R2 storage untouched");

        // R1, R3, R7, R8: full page, lower bank
        write_page(18'h00040, 8'hA5, 32);
        check(page_ready, "R3 ready after 32nd byte", page_ready, 1);
        check(page_base == 13'h0002, "R7 base lower page", page_base, 13'h0002);
        check(bank_hi == 1'b0, "R7 lower bank", bank_hi, 0);
        check_bytes("R8 R1 stored page");

        // R6: write while ready; R5 hold
        expect_ev(EV_OVR, '0);
        wr(18'h00060, 8'h11);
        repeat (4) @(negedge clk);
        check(page_ready, "R5 ready holds without ack", page_ready, 1);
        check_bytes("R6 overrun write ignored");
        ack();
        check(!page_ready, "R5 ack releases page", page_ready, 0);

        // Upper bank page with 0xFF padding
        write_page(18'h20080, 8'h3C, 20);
        check(bank_hi == 1'b1, "R7 upper bank", bank_hi, 1);
        check(page_base == 13'h1004, "R7 base upper page", page_base, 13'h1004);
        check_bytes("R8 padded page");

        // R6 + R5: ack and write in the same cycle
        expect_ev(EV_OVR, '0);
        @(negedge clk);
        page_ack = 1'b1; wr_en = 1'b1; wr_addr = 18'h000A0; wr_data = 8'h77;
        @(negedge clk);
        page_ack = 1'b0; wr_en = 1'b0;
        check(!page_ready, "R5 ack with colliding write", page_ready, 0);
        rd_idx = 5'd0; #1;
        check(page_byte == exp_bytes[0], "R6 colliding write not stored", page_byte, exp_bytes[0]);
        check(page_base == 13'h1004, "R6 base unchanged by collision", page_base, 13'h1004);

        // R4: sequence break
        for (int i = 0; i < 5; i++) wr(18'h000E0 + 18'(i), 8'(8'h40 + i));
        expect_ev(EV_SEQ, '0);
        wr(18'h000E7, 8'h99);
        check(!page_ready, "R4 no ready after break", page_ready, 0);
        for (int i = 0; i < 32; i++) exp_bytes[i] = 8'hFF;
        check_bytes("R4 partial page cleared");
        expect_ev(EV_ALIGN, '0);
        wr(18'h000E6, 8'h12);
        check_bytes("R4 restart requires alignment");

        // R1: recovery with a fresh aligned page
        write_page(18'h000E0, 8'hC3, 32);
        check(page_ready, "R1 new page completes", page_ready, 1);
        check_bytes("R1 R8 recovered page");
        ack();

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R3 all expected events seen", exp_q.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule